// File: doc/BRIEF.md
# Banked Parallel Synaptic Current Accumulator

This block gathers synaptic weight updates for a time-stepped spiking neuron simulator. Each clock it can take up to four (neuron index, weight) pairs and add every weight into a running current total kept for that neuron. The totals are spread over eight memory banks that work independently. A crossbar steers each pair to the bank that owns its index, and each bank has a short queue in front of it. Because of these queues, an uneven spread of pairs over the banks costs nothing until one bank's queue actually runs out of room.

Two complete sets of totals are kept. Updates build up in one set, the accumulation copy. The neuron update pipeline reads finished totals from the other set, the read copy, through a read port with one cycle of latency. At the end of each time step the user pulses a swap request. The block then stops taking input, lets its queues drain, and exchanges the roles of the two copies. It then clears the new accumulation copy to zero, one word per bank per cycle, and opens for input again.

Top module: `syn_current_accum`

## Requirements
- R1: While `inReady` is high, every lane with its `inValid` bit set is taken at the clock edge, and its weight is added to the accumulation-copy total of the neuron named by that lane's index. In `inIndex` and `inWeight`, lane l occupies bits [l*6 +: 6] and [l*12 +: 12] respectively.
- R2: Weights are 12-bit two's complement values. They are sign-extended before the add, so 0x800 stands for -2048 and 0x7FF for +2047.
- R3: Totals are 16-bit two's complement. A result above 32767 is held at 32767 and a result below -32768 is held at -32768. Later updates start from the held value.
- R4: The bank that owns an index is given by index bits [2:0], and bits [5:3] give the word within that bank. `inReady` is high exactly when no swap is in progress and every bank's queue has at least as many free slots as there are valid lanes aimed at it in that cycle. Pairs that reach distinct banks at a steady rate never stall. An idle block accepts any pattern.
- R5: A `stepSwap` pulse seen while `swapBusy` is low raises `swapBusy` on the next cycle. The block then waits until all queues are empty, exchanges the two copies, and spends eight cycles clearing the new accumulation copy. After that `swapBusy` returns low.
- R6: While `swapBusy` is high, `inReady` is low and no valid pair changes any total.
- R7: `rdIndex` is sampled at a clock edge, and `rdTotal` shows the read-copy total of that index after the same edge. After reset both copies read as zero.
- R8: Several updates to the same neuron, whether in one cycle or in back-to-back cycles, are all summed in lane order and then cycle order, and none is lost.
- R9: Once a swap completes, the read copy holds exactly the sums accepted since the previous swap. The new accumulation copy starts from zero, so values from two steps earlier never carry over.
- R10: A `stepSwap` pulse that arrives while `swapBusy` is already high has no effect. Exactly one swap takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 4 | Per-lane valid bits for update pairs |
| inIndex | input | 24 | Four 6-bit neuron indices, lane 0 in the low bits |
| inWeight | input | 48 | Four 12-bit signed weights, lane 0 in the low bits |
| inReady | output | 1 | All valid lanes are taken at this edge |
| stepSwap | input | 1 | Pulse that ends a time step and exchanges the copies |
| swapBusy | output | 1 | A swap (drain, exchange, clear) is in progress |
| rdIndex | input | 6 | Neuron index to read from the read copy |
| rdTotal | output | 16 | Read-copy total of the index sampled at the last edge |

## Verification
`inReady` is a same-cycle function of the queue state and the lanes presented. The bench therefore drives pairs on the falling edge, samples `inReady` 1 ns later, and credits its model only at the rising edge that follows a high sample. `swapBusy` is due one cycle after the edge that sees `stepSwap`, so it is checked at the next falling edge. Accumulated totals can only be observed after a full swap, so every sum check waits for `swapBusy` to fall and then reads through the port. Each read sets `rdIndex` on a falling edge and compares `rdTotal` 1 ns after the following rising edge, which is the one register stage on the read path.

// File: rtl/accum_pkg.sv
package accum_pkg;
  typedef struct packed {
    logic acceptEn;
    logic clearEn;
    logic accSel;
  } accStrobe_t;
endpackage

// File: rtl/accum_ctrl.sv
module accum_ctrl
  import accum_pkg::*;
#(
  parameter int WORDS = 8,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          stepSwap,
  input  logic          dpIdle,
  output accStrobe_t    strb,
  output logic [AW-1:0] clearAddr,
  output logic          swapBusy
);
  typedef enum logic [1:0] {ST_RUN, ST_DRAIN, ST_CLEAR} ctrlState_t;

  ctrlState_t    state;
  logic          accSel;
  logic [AW-1:0] clrAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_RUN;
      accSel  <= 1'b0;
      clrAddr <= '0;
    end else begin
      case (state)
        ST_RUN: if (stepSwap) state <= ST_DRAIN;
        ST_DRAIN: if (dpIdle) begin
          accSel  <= ~accSel;
          clrAddr <= '0;
          state   <= ST_CLEAR;
        end
        ST_CLEAR: begin
          if (clrAddr == AW'(WORDS - 1)) state <= ST_RUN;
          else clrAddr <= clrAddr + AW'(1);
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    strb.acceptEn = (state == ST_RUN);
    strb.clearEn  = (state == ST_CLEAR);
    strb.accSel   = accSel;
  end
  assign clearAddr = clrAddr;
  assign swapBusy  = (state != ST_RUN);
endmodule

// File: rtl/accum_bank.sv
module accum_bank #(
  parameter int LANES  = 4,
  parameter int QDEPTH = 4,
  parameter int WORDS  = 8,
  parameter int AW     = 3,
  parameter int CW     = 3,
  parameter int TW     = 16,
  parameter int WW     = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LANES-1:0]     pushEn,
  input  logic [CW-1:0]        pushOffs   [LANES],
  input  logic [AW-1:0]        pushWord   [LANES],
  input  logic [WW-1:0]        pushWeight [LANES],
  input  logic                 clearEn,
  input  logic [AW-1:0]        clearAddr,
  input  logic                 accSel,
  input  logic [AW-1:0]        rdAddr,
  output logic [CW-1:0]        freeSlots,
  output logic                 empty,
  output logic [TW-1:0]        rdData
);
  localparam int QW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

  logic [AW-1:0] qWord   [QDEPTH];
  logic [WW-1:0] qWeight [QDEPTH];
  logic [QW-1:0] head;
  logic [CW-1:0] count;
  logic [TW-1:0] mem [2][WORDS];

  logic [CW-1:0] nPush;
  logic          pop;
  logic [AW-1:0] headWord;
  logic [WW-1:0] headWeight;
  logic [TW-1:0] cur;
  logic [TW:0]   sum;
  logic [TW-1:0] satV;

  always_comb begin
    nPush = '0;
    for (int l = 0; l < LANES; l++) nPush = nPush + CW'(pushEn[l]);
  end

  assign pop        = (count != '0);
  assign headWord   = qWord[head];
  assign headWeight = qWeight[head];
  assign cur        = mem[accSel][headWord];

  always_comb begin
    sum = {cur[TW-1], cur} + {{(TW + 1 - WW){headWeight[WW-1]}}, headWeight};
    if (sum[TW] != sum[TW-1])
      satV = sum[TW] ? {1'b1, {(TW-1){1'b0}}} : {1'b0, {(TW-1){1'b1}}};
    else
      satV = sum[TW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      head  <= '0;
      count <= '0;
      for (int q = 0; q < QDEPTH; q++) begin
        qWord[q]   <= '0;
        qWeight[q] <= '0;
      end
      for (int c = 0; c < 2; c++)
        for (int w = 0; w < WORDS; w++) mem[c][w] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (pushEn[l]) begin
          qWord[head + QW'(count) + QW'(pushOffs[l])]   <= pushWord[l];
          qWeight[head + QW'(count) + QW'(pushOffs[l])] <= pushWeight[l];
        end
      end
      if (pop) begin
        head <= head + QW'(1);
        mem[accSel][headWord] <= satV;
      end
      count <= count + nPush - CW'(pop);
      if (clearEn) mem[accSel][clearAddr] <= '0;
    end
  end

  assign freeSlots = CW'(QDEPTH) - count;
  assign empty     = (count == '0);
  assign rdData    = mem[~accSel][rdAddr];
endmodule

// File: rtl/accum_datapath.sv
module accum_datapath
  import accum_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int BANKS   = 8,
  parameter int NEURONS = 64,
  parameter int QDEPTH  = 4,
  parameter int WW      = 12,
  parameter int TW      = 16,
  localparam int IW     = $clog2(NEURONS),
  localparam int BW     = $clog2(BANKS),
  localparam int AW     = IW - BW,
  localparam int WORDS  = NEURONS / BANKS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [LANES-1:0]    inValid,
  input  logic [LANES*IW-1:0] inIndex,
  input  logic [LANES*WW-1:0] inWeight,
  output logic                inReady,
  input  accStrobe_t          strb,
  input  logic [AW-1:0]       clearAddr,
  input  logic [IW-1:0]       rdIndex,
  output logic                dpIdle,
  output logic [TW-1:0]       rdTotal
);
  localparam int CMAX = (LANES > QDEPTH) ? LANES : QDEPTH;
  localparam int CW   = $clog2(CMAX + 1);

  logic [BW-1:0] laneBank   [LANES];
  logic [AW-1:0] laneWord   [LANES];
  logic [WW-1:0] laneWeight [LANES];
  logic [BANKS-1:0] roomVec;
  logic [BANKS-1:0] emptyVec;
  logic [TW-1:0]    bankRd [BANKS];

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      laneBank[l]   = inIndex[l*IW +: BW];
      laneWord[l]   = inIndex[l*IW + BW +: AW];
      laneWeight[l] = inWeight[l*WW +: WW];
    end
  end

  assign inReady = strb.acceptEn && (&roomVec);
  assign dpIdle  = &emptyVec;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [LANES-1:0] hit;
    logic [CW-1:0]    offs [LANES];
    logic [CW-1:0]    demand;
    logic [CW-1:0]    freeSlots;
    logic             bankEmpty;

    always_comb begin
      demand = '0;
      for (int l = 0; l < LANES; l++) begin
        hit[l]  = inValid[l] && (laneBank[l] == BW'(b));
        offs[l] = demand;
        if (hit[l]) demand = demand + CW'(1);
      end
    end

    assign roomVec[b]  = (demand <= freeSlots);
    assign emptyVec[b] = bankEmpty;

    accum_bank #(
      .LANES(LANES), .QDEPTH(QDEPTH), .WORDS(WORDS), .AW(AW),
      .CW(CW), .TW(TW), .WW(WW)
    ) u_bank (
      .clk       (clk),
      .rstN      (rstN),
      .pushEn    (hit & {LANES{inReady}}),
      .pushOffs  (offs),
      .pushWord  (laneWord),
      .pushWeight(laneWeight),
      .clearEn   (strb.clearEn),
      .clearAddr (clearAddr),
      .accSel    (strb.accSel),
      .rdAddr    (rdIndex[IW-1:BW]),
      .freeSlots (freeSlots),
      .empty     (bankEmpty),
      .rdData    (bankRd[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdTotal <= '0;
    else       rdTotal <= bankRd[rdIndex[BW-1:0]];
  end
endmodule

// File: rtl/syn_current_accum.sv
module syn_current_accum
  import accum_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int BANKS   = 8,
  parameter int NEURONS = 64,
  parameter int QDEPTH  = 4,
  parameter int WW      = 12,
  parameter int TW      = 16,
  localparam int IW     = $clog2(NEURONS),
  localparam int AW     = IW - $clog2(BANKS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [LANES-1:0]    inValid,
  input  logic [LANES*IW-1:0] inIndex,
  input  logic [LANES*WW-1:0] inWeight,
  output logic                inReady,
  input  logic                stepSwap,
  output logic                swapBusy,
  input  logic [IW-1:0]       rdIndex,
  output logic [TW-1:0]       rdTotal
);
  accStrobe_t    strb;
  logic [AW-1:0] clearAddr;
  logic          dpIdle;

  accum_ctrl #(.WORDS(NEURONS / BANKS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .stepSwap (stepSwap),
    .dpIdle   (dpIdle),
    .strb     (strb),
    .clearAddr(clearAddr),
    .swapBusy (swapBusy)
  );

  accum_datapath #(
    .LANES(LANES), .BANKS(BANKS), .NEURONS(NEURONS),
    .QDEPTH(QDEPTH), .WW(WW), .TW(TW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inIndex  (inIndex),
    .inWeight (inWeight),
    .inReady  (inReady),
    .strb     (strb),
    .clearAddr(clearAddr),
    .rdIndex  (rdIndex),
    .dpIdle   (dpIdle),
    .rdTotal  (rdTotal)
  );
endmodule

// File: rtl/accum_chk.sv
module accum_chk
  import accum_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       stepSwap,
  input logic       swapBusy,
  input logic       inReady,
  input logic       dpIdle,
  input accStrobe_t strb
);
  AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    swapBusy |-> !inReady); // R6

  AST_SWAP_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (stepSwap && !swapBusy) |=> swapBusy); // R5

  AST_CLEAR_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.clearEn) |-> dpIdle); // R5

  AST_CLEAR_FLIPS_COPY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.clearEn) |-> (strb.accSel != $past(strb.accSel))); // R9

  AST_COPY_FIXED_IN_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (!swapBusy && $past(!swapBusy)) |-> $stable(strb.accSel)); // R9

  AST_IDLE_ACCEPTS: assert property (@(posedge clk) disable iff (!rstN)
    (!swapBusy && dpIdle) |-> inReady); // R4
endmodule

bind syn_current_accum accum_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .stepSwap(stepSwap),
  .swapBusy(swapBusy),
  .inReady (inReady),
  .dpIdle  (dpIdle),
  .strb    (strb)
);

// File: tb/tb_syn_current_accum.sv
module tb_syn_current_accum;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  inValid = '0;
  logic [23:0] inIndex = '0;
  logic [47:0] inWeight = '0;
  logic        inReady;
  logic        stepSwap = 1'b0;
  logic        swapBusy;
  logic [5:0]  rdIndex = '0;
  logic [15:0] rdTotal;

  int checks = 0;
  int failures = 0;
  int refAcc [N];
  int refRead [N];
  int lIdx [4];
  int lW [4];
  logic [3:0] lV;
  int stalls;
  int cyc = 0;
  int unsigned rng = 32'h1234_5678;

  always #5 clk = ~clk;

  syn_current_accum dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inIndex(inIndex),
    .inWeight(inWeight), .inReady(inReady), .stepSwap(stepSwap),
    .swapBusy(swapBusy), .rdIndex(rdIndex), .rdTotal(rdTotal)
  );

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int unsigned nextRand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one beat of pairs and hold it until taken; update the model in order.
  task automatic sendBeat();
    @(negedge clk);
    for (int l = 0; l < 4; l++) begin
      inIndex[l*6 +: 6]   = lIdx[l][5:0];
      inWeight[l*12 +: 12] = lW[l][11:0];
    end
    inValid = lV;
    #1;
    while (!inReady) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    for (int l = 0; l < 4; l++)
      if (lV[l]) refAcc[lIdx[l]] = sat16(refAcc[lIdx[l]] + lW[l]);
  endtask

  task automatic dropValid();
    @(negedge clk);
    inValid = '0;
  endtask

  task automatic doSwap(input bit extraPulse);
    @(negedge clk);
    inValid = '0;
    stepSwap = 1'b1;
    @(negedge clk);
    stepSwap = 1'b0;
    check("R5 busy after swap pulse", int'(swapBusy), 1);
    if (extraPulse) begin
      stepSwap = 1'b1;          // R10: pulse while busy
      @(negedge clk);
      stepSwap = 1'b0;
    end
    while (swapBusy) @(negedge clk);
    for (int i = 0; i < N; i++) begin
      refRead[i] = refAcc[i];
      refAcc[i] = 0;
    end
  endtask

  task automatic readAll(input string req);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      rdIndex = 6'(i);
      @(posedge clk);
      #1;
      check(req, int'($signed(rdTotal)), refRead[i]);
    end
  endtask

  initial begin
    while (cyc < 100000) @(posedge clk) cyc++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin refAcc[i] = 0; refRead[i] = 0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R7 reset swapBusy", int'(swapBusy), 0);
    #1;
    check("R4 idle ready", int'(inReady), 1);
    readAll("R7 reset totals zero");

    // R1 R2 R4: sweep of every index, lanes hit distinct banks
    stalls = 0;
    for (int c = 0; c < 16; c++) begin
      lV = 4'hF;
      for (int l = 0; l < 4; l++) begin
        lIdx[l] = c*4 + l;
        lW[l] = ((lIdx[l]*37 + c*11) % 4096) - 2048;
      end
      sendBeat();
    end
    dropValid();
    check("R4 no stall on spread banks", stalls, 0);
    doSwap(1'b0);
    readAll("R1 R2 sweep totals");

    // R8 R4: all lanes to one neuron, back to back, plus a same-bank pair
    stalls = 0;
    for (int c = 0; c < 6; c++) begin
      lV = 4'hF;
      for (int l = 0; l < 4; l++) begin lIdx[l] = 13; lW[l] = c*100 + l - 300; end
      sendBeat();
    end
    lV = 4'b0101; lIdx[0] = 21; lIdx[2] = 29; lW[0] = 7; lW[2] = -9;
    lIdx[1] = 0; lIdx[3] = 0; lW[1] = 0; lW[3] = 0;
    sendBeat();
    dropValid();
    check("R4 stall on bank overload", int'(stalls > 0), 1);
    doSwap(1'b0);
    readAll("R8 same neuron sums");
    readAll("R9 sweep values cleared");

    // R3: saturation both ways, then recovery from held value
    for (int c = 0; c < 20; c++) begin
      lV = 4'b0011; lIdx[0] = 5; lW[0] = 2047; lIdx[1] = 6; lW[1] = -2048;
      lIdx[2] = 0; lIdx[3] = 0; lW[2] = 0; lW[3] = 0;
      sendBeat();
    end
    lV = 4'b0011; lIdx[0] = 5; lW[0] = -100; lIdx[1] = 6; lW[1] = 100;
    sendBeat();
    dropValid();
    check("R3 model max held", refAcc[5], 32667);
    doSwap(1'b0);
    readAll("R3 saturated totals");

    // R6 R10: pair offered during swap is refused; second pulse ignored
    lV = 4'b0001; lIdx[0] = 3; lW[0] = 500; lIdx[1] = 0; lIdx[2] = 0; lIdx[3] = 0;
    lW[1] = 0; lW[2] = 0; lW[3] = 0;
    sendBeat();
    dropValid();
    @(negedge clk);
    stepSwap = 1'b1;
    @(negedge clk);
    stepSwap = 1'b0;
    inValid = 4'b0001;
    inIndex[5:0] = 6'd9;
    inWeight[11:0] = 12'd100;
    #1;
    check("R6 ready low during swap", int'(inReady), 0);
    inValid = '0;
    stepSwap = 1'b1;            // R10: second pulse while busy
    @(negedge clk);
    stepSwap = 1'b0;
    while (swapBusy) @(negedge clk);
    for (int i = 0; i < N; i++) begin refRead[i] = refAcc[i]; refAcc[i] = 0; end
    repeat (3) @(negedge clk);
    check("R10 no second swap", int'(swapBusy), 0);
    readAll("R6 R10 single swap contents");
    doSwap(1'b1);
    readAll("R9 empty step reads zero");

    // R1 R8: pseudo-random lane patterns
    stalls = 0;
    for (int c = 0; c < 200; c++) begin
      lV = 4'(nextRand());
      for (int l = 0; l < 4; l++) begin
        lIdx[l] = int'(nextRand() % 64);
        lW[l] = int'(nextRand() % 4096) - 2048;
      end
      sendBeat();
    end
    dropValid();
    doSwap(1'b0);
    readAll("R1 random totals");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule